// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns a single 32-bit register write into software interrupts for one or more processors. The write carries an interrupt number, a two-bit destination selector and a list of processors. The block also takes the index of the processor that made the write. From these it works out which processors are addressed and sets, for each of them, the pending bit for that interrupt number. Every processor has its own bank of pending bits, one per software interrupt number. All banks are visible on one flat output vector.

Each processor's interface can clear one of its own pending bits per cycle when it acknowledges an interrupt. The dispatcher never clears a bit by itself. Arbitration between pending interrupts and the bus that carries the write belong to other blocks. Only whole-word writes start a dispatch. Narrower writes are dropped.

Top module: `sgi_dispatch`

## Requirements
- R1: While `rst_n` is low, every bit of `pend_o` is 0.
- R2: A dispatch happens only when `wr_en` is 1 and all four bits of `wr_be` are 1. Any other write leaves `pend_o` unchanged.
- R3: The interrupt number is `wr_data[9:0]`. A value of `NUM_ID` (16) or above sets no bit.
- R4: When the selector `wr_data[25:24]` is 0, the destinations are the bits of `wr_data[23:16]`, where bit 16+n addresses processor n. Bits for processors at or above `NUM_CPU` are dropped.
- R5: Selector 1 addresses every existing processor except the writer given on `wr_cpu`.
- R6: Selector 2 addresses only the writer given on `wr_cpu`.
- R7: Selector 3 addresses every existing processor, whatever the list field holds.
- R8: Processor c's pending bit for interrupt i is `pend_o[c*NUM_ID+i]`. It reads 1 after the clock edge that samples the dispatching write.
- R9: When `ack_vld[c]` is 1, the bit for `ack_id[c]` of processor c is cleared at the next edge. No other bit is affected.
- R10: If a dispatch and an acknowledge hit the same bit in the same cycle, the bit ends up 1.
- R11: A dispatch never clears a pending bit, including bits of the interrupt number it writes on other processors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write to the dispatch register |
| wr_be | input | 4 | Byte enables of that write |
| wr_cpu | input | CPU_W | Index of the writing processor |
| wr_data | input | 32 | Write value: number, list, selector |
| ack_vld | input | NUM_CPU | Per-processor acknowledge strobe |
| ack_id | input | NUM_CPU*ID_W | Per-processor acknowledged number, processor c at bits c*ID_W |
| pend_o | output | NUM_CPU*NUM_ID | Pending bits, processor-major |

## Verification
There is one register between every input and `pend_o`. The bench drives the inputs on a falling edge and samples `pend_o` on the next falling edge, after the single rising edge that takes the write or acknowledge in. An acknowledge that follows a dispatch is driven one cycle later, so each dispatch result is checked before it is consumed. The reset check is taken shortly after `rst_n` falls, because reset acts without a clock.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int ID_LSB   = 0;
  localparam int ID_BITS  = 10;
  localparam int LIST_LSB = 16;
  localparam int SEL_LSB  = 24;

  typedef enum logic [1:0] {
    SEL_LIST   = 2'd0,
    SEL_OTHERS = 2'd1,
    SEL_SELF   = 2'd2,
    SEL_ALL    = 2'd3
  } sgi_sel_e;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_ID  = 16,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int ID_W    = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_be,
  input  logic [CPU_W-1:0]   wr_cpu,
  input  logic [31:0]        wr_data,
  output logic               set_vld,
  output logic [ID_W-1:0]    set_id,
  output logic [NUM_CPU-1:0] set_mask
);
  localparam logic [NUM_CPU-1:0] ALL_CPU = {NUM_CPU{1'b1}};

  logic               full_wr;
  logic               id_ok;
  logic [ID_BITS-1:0] id_raw;
  logic [NUM_CPU-1:0] self_mask;
  logic [NUM_CPU-1:0] list_mask;
  sgi_sel_e           sel;

  assign full_wr   = wr_en & (&wr_be);
  assign id_raw    = wr_data[ID_LSB +: ID_BITS];
  assign id_ok     = (id_raw < ID_BITS'(NUM_ID));
  assign list_mask = wr_data[LIST_LSB +: NUM_CPU];
  assign sel       = sgi_sel_e'(wr_data[SEL_LSB +: 2]);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_self
    assign self_mask[c] = (wr_cpu == CPU_W'(c));
  end

  always_comb begin
    unique case (sel)
      SEL_LIST:   set_mask = list_mask;
      SEL_OTHERS: set_mask = ALL_CPU & ~self_mask;
      SEL_SELF:   set_mask = self_mask;
      default:    set_mask = ALL_CPU;
    endcase
  end

  assign set_vld = full_wr & id_ok;
  assign set_id  = id_raw[ID_W-1:0];

  AST_OTHERS_SKIP_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && sel == SEL_OTHERS) |-> ((set_mask & self_mask) == '0)); // R5
endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
  parameter int NUM_ID = 16,
  parameter int ID_W   = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ID_W-1:0]   set_id,
  input  logic              ack_vld,
  input  logic [ID_W-1:0]   ack_id,
  output logic [NUM_ID-1:0] pend_q
);
  logic [NUM_ID-1:0] set_vec;
  logic [NUM_ID-1:0] clr_vec;
  logic [NUM_ID-1:0] pend_d;
  logic              upd;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (set_en)  set_vec[set_id] = 1'b1;
    if (ack_vld) clr_vec[ack_id] = 1'b1;
    pend_d = set_vec | (pend_q & ~clr_vec);
    upd    = set_en | ack_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend_q[$past(set_id)]); // R11
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && ack_vld && set_id == ack_id) |=> pend_q[$past(ack_id)]); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !(set_en && set_id == ack_id)) |=> !pend_q[$past(ack_id)]); // R9
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_ID  = 16,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int ID_W    = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [3:0]                wr_be,
  input  logic [CPU_W-1:0]          wr_cpu,
  input  logic [31:0]               wr_data,
  input  logic [NUM_CPU-1:0]        ack_vld,
  input  logic [NUM_CPU*ID_W-1:0]   ack_id,
  output logic [NUM_CPU*NUM_ID-1:0] pend_o
);
  localparam int PEND_W = NUM_CPU * NUM_ID;

  logic               set_vld;
  logic [ID_W-1:0]    set_id;
  logic [NUM_CPU-1:0] set_mask;

  sgi_decode #(
    .NUM_CPU (NUM_CPU),
    .NUM_ID  (NUM_ID),
    .CPU_W   (CPU_W),
    .ID_W    (ID_W)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .wr_cpu   (wr_cpu),
    .wr_data  (wr_data),
    .set_vld  (set_vld),
    .set_id   (set_id),
    .set_mask (set_mask)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    sgi_pend_bank #(
      .NUM_ID (NUM_ID),
      .ID_W   (ID_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_vld & set_mask[c]),
      .set_id  (set_id),
      .ack_vld (ack_vld[c]),
      .ack_id  (ack_id[c*ID_W +: ID_W]),
      .pend_q  (pend_o[c*NUM_ID +: NUM_ID])
    );
  end

  AST_PARTIAL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (&wr_be)) |=> ((pend_o & ~$past(pend_o)) == PEND_W'(0))); // R2
  AST_HIGH_ID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data[ID_LSB +: ID_BITS] >= ID_BITS'(NUM_ID)) |=> ((pend_o & ~$past(pend_o)) == PEND_W'(0))); // R3
endmodule

// File: tb/tb_sgi_dispatch.sv
module tb_sgi_dispatch;
  localparam int NCPU = 6;
  localparam int NID  = 16;
  localparam int CPUW = 3;
  localparam int IDW  = 4;
  localparam int PW   = NCPU * NID;
  localparam int NVEC = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [3:0]      wr_be;
  logic [CPUW-1:0] wr_cpu;
  logic [31:0]     wr_data;
  logic [NCPU-1:0] ack_vld;
  logic [NCPU*IDW-1:0] ack_id;
  logic [PW-1:0]   pend_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  sgi_dispatch #(.NUM_CPU(NCPU), .NUM_ID(NID)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_cpu(wr_cpu),
    .wr_data(wr_data), .ack_vld(ack_vld), .ack_id(ack_id), .pend_o(pend_o)
  );

  // {en, be, cpu, data, expected processor mask, expected id}
  localparam logic [51:0] VEC [NVEC] = '{
    {1'b1, 4'hF, 3'd2, 6'd0, 2'd0, 8'h05, 6'd0, 10'd3,   8'h05, 4'd3},  // R4 list
    {1'b1, 4'hF, 3'd2, 6'd0, 2'd0, 8'hFF, 6'd0, 10'd15,  8'h3F, 4'd15}, // R4 mask to existing
    {1'b1, 4'hF, 3'd0, 6'd0, 2'd1, 8'h00, 6'd0, 10'd7,   8'h3E, 4'd7},  // R5
    {1'b1, 4'hF, 3'd5, 6'd0, 2'd1, 8'hFF, 6'd0, 10'd0,   8'h1F, 4'd0},  // R5
    {1'b1, 4'hF, 3'd4, 6'd0, 2'd2, 8'h01, 6'd0, 10'd9,   8'h10, 4'd9},  // R6
    {1'b1, 4'hF, 3'd1, 6'd0, 2'd3, 8'h02, 6'd0, 10'd12,  8'h3F, 4'd12}, // R7
    {1'b1, 4'h7, 3'd0, 6'd0, 2'd3, 8'h00, 6'd0, 10'd1,   8'h00, 4'd1},  // R2 partial
    {1'b0, 4'hF, 3'd0, 6'd0, 2'd3, 8'h00, 6'd0, 10'd1,   8'h00, 4'd1},  // R2 no enable
    {1'b1, 4'hF, 3'd0, 6'd0, 2'd3, 8'h00, 6'd0, 10'd16,  8'h00, 4'd0},  // R3
    {1'b1, 4'hF, 3'd0, 6'd0, 2'd3, 8'h00, 6'd0, 10'd1023,8'h00, 4'd15}, // R3
    {1'b1, 4'hF, 3'd3, 6'd0, 2'd0, 8'hC0, 6'd0, 10'd2,   8'h00, 4'd2},  // R4 absent cpus
    {1'b1, 4'hF, 3'd3, 6'h3F, 2'd0, 8'h03, 6'h3F, 10'd5, 8'h03, 4'd5}   // R8 junk bits
  };

  function automatic logic [PW-1:0] place(input logic [7:0] m, input logic [3:0] id);
    logic [PW-1:0] r = '0;
    for (int c = 0; c < NCPU; c++) if (m[c]) r[c*NID + id] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] exp);
    checks++;
    if (pend_o !== exp) begin
      errors++;
      $display("FAIL %s: pend_o=%h expected=%h", req, pend_o, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_be = 4'h0; wr_cpu = '0; wr_data = '0;
    ack_vld = '0; ack_id = '0;
  endtask

  task automatic put_write(input logic [CPUW-1:0] cpu, input logic [1:0] sel,
                           input logic [7:0] list, input int id);
    wr_en = 1'b1; wr_be = 4'hF; wr_cpu = cpu;
    wr_data = {6'd0, sel, list, 6'd0, 10'(id)};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    #1;
    check("R1 reset", '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0);

    for (int i = 0; i < NVEC; i++) begin
      logic [51:0] v;
      v = VEC[i];
      wr_en = v[51]; wr_be = v[50:47]; wr_cpu = v[46:44]; wr_data = v[43:12];
      @(negedge clk);
      idle();
      check($sformatf("R8 vector %0d", i), place(v[11:4], v[3:0]));
      ack_vld = '1; ack_id = {NCPU{v[3:0]}};
      @(negedge clk);
      idle();
      check($sformatf("R9 vector %0d ack", i), '0);
    end

    // R11: second dispatch of the same number keeps the first processor's bit
    put_write(3'd1, 2'd2, 8'h00, 4);
    @(negedge clk);
    put_write(3'd3, 2'd2, 8'h00, 4);
    @(negedge clk);
    idle();
    check("R11 no clear", place(8'h0A, 4'd4));

    // R9: acknowledge on processor 1 only
    ack_vld = 6'b000010; ack_id = {NCPU{4'd4}};
    @(negedge clk);
    idle();
    check("R9 single clear", place(8'h08, 4'd4));

    // R10: dispatch and acknowledge of the same bit together
    put_write(3'd3, 2'd2, 8'h00, 4);
    ack_vld = 6'b001000; ack_id = {NCPU{4'd4}};
    @(negedge clk);
    idle();
    check("R10 set wins", place(8'h08, 4'd4));

    // R9: acknowledge of an unset number leaves others alone
    ack_vld = 6'b001000; ack_id = {NCPU{4'd7}};
    @(negedge clk);
    idle();
    check("R9 unset ack", place(8'h08, 4'd4));

    // R1: reset in mid-run clears everything
    put_write(3'd0, 2'd3, 8'h00, 9);
    @(negedge clk);
    idle();
    check("R7 before reset", place(8'h08, 4'd4) | place(8'h3F, 4'd9));
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule